// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the clock timing for an I2C master. It runs from a fast source clock and drives SCL itself. It also gives a byte engine single-cycle phase ticks: SCL rising, SCL falling, the point in the low phase where SDA may change, and the end of the setup time before a START. The bus period comes from three nested counts. A clock prescaler produces divider strobes. A sample counter groups the strobes into sample ticks. A step counter counts sample ticks within each SCL phase. The high phase and the low phase each have their own step count and their own sample count, so the duty cycle can be set freely while the period stays fixed.

Settings arrive as three 16-bit timing words, a divider value and an SDA-change step. The block captures all of them only at a START event, so the byte engine can rewrite them during a transfer without disturbing it. A START event is either `run` rising out of idle or a repeated-START request that is served at the end of a high phase. When the setup step is enabled, the block first holds SCL high for a count of raw source-clock cycles that ignores the prescaler. It then raises the START tick and enters a high phase that serves as the START hold. After that, low and high phases alternate.

States:
- `PH_IDLE`: SCL is high and all counters are cleared.
- `PH_SETUP`: the raw-cycle START setup count runs, with SCL high.
- `PH_HIGH`: SCL is high.
- `PH_LOW`: SCL is low.

Transitions:
- IDLE→SETUP: `run` is high and setup is enabled.
- IDLE→HIGH: `run` is high and setup is bypassed.
- SETUP→HIGH: the setup count is done.
- HIGH→LOW: the high steps are done and no restart is pending.
- HIGH→SETUP or HIGH→HIGH: the high steps are done and a restart is pending. The target depends on whether setup is enabled.
- LOW→HIGH: the low steps are done.
- any→IDLE: `run` is low.

Top module: `i2c_scl_tgen`

## Requirements
- R1: While `run` is low, and after reset, `scl_o` is 1 and all four ticks are 0. Dropping `run` forces `scl_o` high from the next clock cycle.
- R2: The low phase lasts (div+1)·(ls+1)·(lo+1) source cycles, measured from `tick_fall` to `tick_rise`. Here div is `cfg_div_m1`, ls is `cfg_ltime[8:6]` and lo is `cfg_ltime[5:0]`.
- R3: The high phase lasts (div+1)·(hs+1)·(hi+1) cycles, measured from `tick_rise` to the next `tick_fall`. Here hs is `cfg_htime[10:8]` and hi is `cfg_htime[5:0]`. With equal settings for both phases, the period is 2·(div+1)·(s+1)·(n+1).
- R4: `tick_sda` pulses (div+1)·(ls+1)·min(`cfg_sda_pt`, lo) cycles after `tick_fall`. A value of 0 puts it in the same cycle as `tick_fall`. A value larger than lo is clamped to lo.
- R5: When `cfg_ext[0]`=1, a START holds SCL high for `cfg_ext[15:8]`+1 raw source cycles (1 to 256) and then pulses `tick_sta`. If `run` is set before clock edge k, `tick_sta` is high in cycle k+`cfg_ext[15:8]`+1. The divider has no effect on this count.
- R6: When `cfg_ext[0]`=0, the setup is skipped and `tick_sta` is high in the first cycle after the START event.
- R7: The block captures configuration only at a START event. Changes to the inputs at any other time have no effect on the timing.
- R8: A pulse on `restart_req` lets the current high phase finish. SCL then stays high through the new setup, with no `tick_fall` before `tick_sta`, and the new configuration applies from that point on.
- R9: Each tick is a single-cycle pulse. `tick_rise` and `tick_fall` are never high together. After `tick_sta`, one full high phase (the START hold) passes before the first `tick_fall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Enables the generator; low returns it to idle |
| restart_req | input | 1 | One-cycle request for a repeated START |
| cfg_div_m1 | input | DIV_W | Prescaler divide value minus one |
| cfg_htime | input | 16 | High timing word: [10:8] sample count − 1, [5:0] step count − 1 |
| cfg_ltime | input | 16 | Low timing word: [8:6] sample count − 1, [5:0] step count − 1 |
| cfg_ext | input | 16 | [15:8] START setup cycles − 1, [0] setup enable |
| cfg_sda_pt | input | 6 | Low-phase step at which SDA may change |
| scl_o | output | 1 | SCL level (1 = released high) |
| tick_rise | output | 1 | Pulses in the first cycle of SCL high after low |
| tick_fall | output | 1 | Pulses in the first cycle of SCL low |
| tick_sda | output | 1 | Pulses at the SDA change point |
| tick_sta | output | 1 | Pulses when the START setup is complete |

## Verification
The bench aims at the counter edges where an off-by-one hides:
- With every count at zero, each phase must last exactly one cycle. A counter that compares before it increments would stretch this to two.
- An SDA point of 0 must land on the falling tick itself, and a point past the low count must clamp. A design that got these wrong would drop the tick or place it on the rising edge.
- The setup count runs to its 256-cycle maximum with a large divider programmed. This catches a field that wraps to 0, or a setup counter wrongly driven by the prescaler.
- Configuration is rewritten mid-transfer and then a restart is requested. This exposes a design that applies new settings early, or one that lets SCL fall during the restart setup.

// File: rtl/i2c_tgen_pkg.sv
package i2c_tgen_pkg;

    localparam int WORD_W      = 16;
    localparam int STEP_W      = 6;
    localparam int SAMP_W      = 3;
    localparam int STA_W       = 8;
    localparam int HI_SAMP_LSB = 8;
    localparam int LO_SAMP_LSB = 6;
    localparam int STA_LSB     = 8;
    localparam int STA_EN_BIT  = 0;

    typedef logic [STEP_W-1:0] step_t;
    typedef logic [SAMP_W-1:0] samp_t;
    typedef logic [STA_W-1:0]  sta_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_HIGH  = 2'd2,
        PH_LOW   = 2'd3
    } phase_e;

    typedef struct packed {
        step_t hi_m1;
        samp_t hsamp_m1;
        step_t lo_m1;
        samp_t lsamp_m1;
        sta_t  sta_m1;
        logic  sta_en;
        step_t sda_pt;
    } tcfg_t;

    function automatic tcfg_t unpack_cfg(input word_t htime, input word_t ltime,
                                         input word_t ext, input step_t sda_pt);
        tcfg_t c;
        c.hi_m1    = htime[STEP_W-1:0];
        c.hsamp_m1 = htime[HI_SAMP_LSB +: SAMP_W];
        c.lo_m1    = ltime[STEP_W-1:0];
        c.lsamp_m1 = ltime[LO_SAMP_LSB +: SAMP_W];
        c.sta_m1   = ext[STA_LSB +: STA_W];
        c.sta_en   = ext[STA_EN_BIT];
        c.sda_pt   = sda_pt;
        return c;
    endfunction

endpackage

// File: rtl/i2c_tgen_prescale.sv
module i2c_tgen_prescale #(
    parameter int DIV_W  = 4,
    parameter int SAMP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [DIV_W-1:0]  div_m1,
    input  logic [SAMP_W-1:0] samp_m1,
    output logic              samp_tick
);

    logic [DIV_W-1:0]  div_cnt;
    logic [SAMP_W-1:0] samp_cnt;
    logic              div_hit;

    assign div_hit   = en && (div_cnt == div_m1);
    assign samp_tick = div_hit && (samp_cnt == samp_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt  <= '0;
            samp_cnt <= '0;
        end else if (clr) begin
            div_cnt  <= '0;
            samp_cnt <= '0;
        end else if (en) begin
            if (div_hit) begin
                div_cnt  <= '0;
                samp_cnt <= samp_tick ? '0 : samp_cnt + 1'b1;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    // R2 / R3: neither nested count may run past its programmed limit
    assert_div_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        div_cnt <= div_m1);
    assert_samp_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        samp_cnt <= samp_m1);

endmodule

// File: rtl/i2c_tgen_stepcnt.sv
module i2c_tgen_stepcnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         last
);

    assign last = adv && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || last) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: a step count never runs beyond its limit
    assert_step_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= limit);

endmodule

// File: rtl/i2c_scl_tgen.sv
module i2c_scl_tgen
    import i2c_tgen_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart_req,
    input  logic [DIV_W-1:0] cfg_div_m1,
    input  logic [15:0]      cfg_htime,
    input  logic [15:0]      cfg_ltime,
    input  logic [15:0]      cfg_ext,
    input  logic [5:0]       cfg_sda_pt,
    output logic             scl_o,
    output logic             tick_rise,
    output logic             tick_fall,
    output logic             tick_sda,
    output logic             tick_sta
);

    localparam int CMP_W = STEP_W + 1;

    phase_e           state, state_nxt;
    tcfg_t            cfg_in, cfg_q;
    logic [DIV_W-1:0] div_q;
    logic             rs_pend;
    logic             start_evt;
    logic             in_phase;
    logic             clr_phase, clr_sta;
    logic             samp_tick;
    step_t            ph_cnt, ph_lim, sda_eff;
    samp_t            samp_sel;
    logic             ph_last;
    sta_t             sta_cnt;
    logic             sta_last;
    logic             sda_hit;
    logic             unused_cfg_bits;

    assign cfg_in = unpack_cfg(cfg_htime, cfg_ltime, cfg_ext, cfg_sda_pt);
    assign unused_cfg_bits = ^{cfg_htime[15:11], cfg_htime[7:6], cfg_ltime[15:9], cfg_ext[7:1]};

    // ---------------- datapath selection ----------------
    assign in_phase = (state == PH_HIGH) || (state == PH_LOW);
    assign ph_lim   = (state == PH_LOW) ? cfg_q.lo_m1    : cfg_q.hi_m1;
    assign samp_sel = (state == PH_LOW) ? cfg_q.lsamp_m1 : cfg_q.hsamp_m1;
    assign sda_eff  = (cfg_q.sda_pt > cfg_q.lo_m1) ? cfg_q.lo_m1 : cfg_q.sda_pt;

    assign start_evt = run && ((state == PH_IDLE) ||
                               ((state == PH_HIGH) && ph_last && rs_pend));

    assign clr_phase = !in_phase || (state_nxt != state) || ph_last;
    assign clr_sta   = (state != PH_SETUP);

    i2c_tgen_prescale #(
        .DIV_W  (DIV_W),
        .SAMP_W (SAMP_W)
    ) u_prescale (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_phase),
        .en        (in_phase),
        .div_m1    (div_q),
        .samp_m1   (samp_sel),
        .samp_tick (samp_tick)
    );

    i2c_tgen_stepcnt #(
        .W (STEP_W)
    ) u_phase_steps (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_phase),
        .adv   (samp_tick && in_phase),
        .limit (ph_lim),
        .cnt   (ph_cnt),
        .last  (ph_last)
    );

    i2c_tgen_stepcnt #(
        .W (STA_W)
    ) u_setup_cycles (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_sta),
        .adv   (state == PH_SETUP),
        .limit (cfg_q.sta_m1),
        .cnt   (sta_cnt),
        .last  (sta_last)
    );

    // ---------------- configuration capture ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            div_q <= '0;
        end else if (start_evt) begin
            cfg_q <= cfg_in;
            div_q <= cfg_div_m1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_pend <= 1'b0;
        end else if (!run || start_evt) begin
            rs_pend <= 1'b0;
        end else if (restart_req) begin
            rs_pend <= 1'b1;
        end
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_nxt = state;
        if (!run) begin
            state_nxt = PH_IDLE;
        end else begin
            unique case (state)
                PH_IDLE: begin
                    state_nxt = cfg_in.sta_en ? PH_SETUP : PH_HIGH;
                end
                PH_SETUP: begin
                    if (sta_last) state_nxt = PH_HIGH;
                end
                PH_HIGH: begin
                    if (ph_last) begin
                        if (rs_pend) state_nxt = cfg_in.sta_en ? PH_SETUP : PH_HIGH;
                        else         state_nxt = PH_LOW;
                    end
                end
                PH_LOW: begin
                    if (ph_last) state_nxt = PH_HIGH;
                end
                default: state_nxt = PH_IDLE;
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_IDLE;
        else        state <= state_nxt;
    end

    // ---------------- registered outputs ----------------
    assign sda_hit = (state == PH_LOW) && (state_nxt == PH_LOW) && samp_tick &&
                     (CMP_W'(ph_cnt) + CMP_W'(1) == CMP_W'(sda_eff));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_o     <= 1'b1;
            tick_rise <= 1'b0;
            tick_fall <= 1'b0;
            tick_sda  <= 1'b0;
            tick_sta  <= 1'b0;
        end else begin
            scl_o     <= (state_nxt != PH_LOW);
            tick_fall <= (state == PH_HIGH) && (state_nxt == PH_LOW);
            tick_rise <= (state == PH_LOW) && (state_nxt == PH_HIGH);
            tick_sta  <= (state_nxt == PH_HIGH) && ((state == PH_SETUP) || start_evt);
            tick_sda  <= ((state == PH_HIGH) && (state_nxt == PH_LOW) && (sda_eff == '0))
                         || sda_hit;
        end
    end

    // ---------------- assertions ----------------
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (scl_o && !tick_rise && !tick_fall && !tick_sda && !tick_sta));

    assert_fall_is_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_fall |-> (!scl_o && $past(scl_o)));

    assert_rise_is_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_rise |-> (scl_o && !$past(scl_o)));

    assert_sda_in_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_sda |-> !scl_o);

    assert_sta_while_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_sta |-> scl_o);

    assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !start_evt |=> $stable(cfg_q));

    assert_setup_keeps_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_SETUP) |-> scl_o);

    assert_edges_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tick_rise, tick_fall}));

endmodule

// File: tb/i2c_scl_tgen_tb_top.sv
`timescale 1ns/1ps
module i2c_scl_tgen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        restart_req = 1'b0;
    logic [3:0]  cfg_div_m1 = '0;
    logic [15:0] cfg_htime = '0;
    logic [15:0] cfg_ltime = '0;
    logic [15:0] cfg_ext = '0;
    logic [5:0]  cfg_sda_pt = '0;
    logic        scl_o, tick_rise, tick_fall, tick_sda, tick_sta;

    int checks = 0;
    int errors = 0;
    int fall_seen = 0;

    always #4 clk = ~clk;

    i2c_scl_tgen #(.DIV_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .run(run), .restart_req(restart_req),
        .cfg_div_m1(cfg_div_m1), .cfg_htime(cfg_htime), .cfg_ltime(cfg_ltime),
        .cfg_ext(cfg_ext), .cfg_sda_pt(cfg_sda_pt),
        .scl_o(scl_o), .tick_rise(tick_rise), .tick_fall(tick_fall),
        .tick_sda(tick_sda), .tick_sta(tick_sta)
    );

    always @(negedge clk) if (tick_fall) fall_seen++;

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
        finish_run();
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic ev(input int which);
        case (which)
            0: return tick_rise;
            1: return tick_fall;
            2: return tick_sda;
            default: return tick_sta;
        endcase
    endfunction

    // counts falling clock edges until the selected tick is seen
    task automatic wait_tick(input int which, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ev(which) && n < 5000);
    endtask

    // from the next falling tick: cycles to the SDA tick and to the rising tick
    task automatic measure_low(output int t_sda, output int t_rise);
        int n;
        int c;
        wait_tick(1, n);
        c = 0;
        t_sda = tick_sda ? 0 : -1;
        do begin
            @(negedge clk);
            c++;
            if (tick_sda && t_sda < 0) t_sda = c;
        end while (!tick_rise && c < 5000);
        t_rise = c;
    endtask

    task automatic set_cfg(input int div, input int hs, input int hi, input int ls,
                           input int lo, input int sta, input int en, input int sda);
        cfg_div_m1 = 4'(div);
        cfg_htime  = {5'b0, 3'(hs), 2'b0, 6'(hi)};
        cfg_ltime  = {7'b0, 3'(ls), 6'(lo)};
        cfg_ext    = {8'(sta), 7'b0, 1'(en)};
        cfg_sda_pt = 6'(sda);
    endtask

    task automatic start_run(input string req, input int exp_n);
        int n;
        @(negedge clk);
        run = 1'b1;
        wait_tick(3, n);
        chk(req, n, exp_n);
    endtask

    task automatic stop_run();
        int bad = 0;
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        chk("R1 scl high after run drop", int'(scl_o), 1);
        repeat (20) begin
            @(negedge clk);
            if (!scl_o || tick_rise || tick_fall || tick_sda || tick_sta) bad++;
        end
        chk("R1 quiet while stopped", bad, 0);
    endtask

    task automatic t_reset();
        int bad = 0;
        chk("R1 reset scl", int'(scl_o), 1);
        chk("R1 reset ticks", int'({tick_rise, tick_fall, tick_sda, tick_sta}), 0);
        repeat (40) begin
            @(negedge clk);
            if (!scl_o || tick_rise || tick_fall || tick_sda || tick_sta) bad++;
        end
        chk("R1 idle with run low", bad, 0);
    endtask

    task automatic t_symmetric();
        int n, s, r;
        set_cfg(0, 0, 3, 0, 3, 9, 1, 2);
        start_run("R5 setup of 10 cycles", 11);
        wait_tick(1, n);
        chk("R9 START hold is one high phase", n, 4);
        measure_low(s, r);
        chk("R2 low length", r, 4);
        chk("R4 sda point", s, 2);
        wait_tick(1, n);
        chk("R3 high length", n, 4);
        wait_tick(0, n);
        wait_tick(0, r);
        chk("R3 period 2*D*S*N", r, 8);
        stop_run();
    endtask

    task automatic t_asymmetric();
        int n, s, r;
        set_cfg(2, 3, 1, 1, 4, 0, 1, 2);
        start_run("R5 setup of 1 cycle", 2);
        wait_tick(1, n);
        chk("R9 hold with divided high", n, 24);
        measure_low(s, r);
        chk("R2 divided low length", r, 30);
        chk("R4 divided sda point", s, 12);
        wait_tick(1, n);
        chk("R3 divided high length", n, 24);
        stop_run();
    endtask

    task automatic t_sda_clamp();
        int s, r;
        set_cfg(2, 3, 1, 1, 4, 0, 1, 7);
        start_run("R5 setup again", 2);
        measure_low(s, r);
        chk("R4 sda clamped to last step", s, 24);
        chk("R2 low unchanged by sda", r, 30);
        stop_run();
    endtask

    task automatic t_minimum();
        int n, s, r;
        set_cfg(0, 0, 0, 0, 0, 0, 0, 5);
        start_run("R6 setup bypassed", 1);
        measure_low(s, r);
        chk("R2 one-cycle low", r, 1);
        chk("R4 sda on the falling tick", s, 0);
        wait_tick(1, n);
        chk("R3 one-cycle high", n, 1);
        stop_run();
    endtask

    task automatic t_setup_max();
        set_cfg(5, 0, 1, 0, 1, 255, 1, 0);
        start_run("R5 setup of 256 raw cycles", 257);
        stop_run();
    endtask

    task automatic t_cfg_hold_restart();
        int n, s, r, f0;
        set_cfg(0, 0, 3, 0, 3, 9, 1, 2);
        start_run("R5 setup before restart", 11);
        set_cfg(2, 3, 1, 1, 4, 3, 1, 2);
        measure_low(s, r);
        chk("R7 low ignores new inputs", r, 4);
        chk("R7 sda ignores new inputs", s, 2);
        f0 = fall_seen;
        restart_req = 1'b1;
        @(negedge clk);
        restart_req = 1'b0;
        wait_tick(3, n);
        chk("R8 restart after high then new setup", n + 1, 8);
        chk("R8 no fall before restart START", fall_seen - f0, 0);
        wait_tick(1, n);
        chk("R8 hold uses new high", n, 24);
        measure_low(s, r);
        chk("R7 new low after restart", r, 30);
        stop_run();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_symmetric();
        t_asymmetric();
        t_sda_clamp();
        t_minimum();
        t_setup_max();
        t_cfg_hold_restart();
        finish_run();
    end

endmodule